// File: doc/BRIEF.md
# Bus-Takeover RAM Bootstrap Loader

This controller fills the system RAM of a small 8-bit computer with a program image and then starts the processor on it. While it waits, the processor keeps the bus and runs freely on whatever RAM holds. The first image byte on the byte-stream input starts a load. The loader drives its bus-enable output low, which floats the processor's address, data and control pins. It also enables the outputs of two external cascaded 8-bit address shift registers.

For every byte, the loader shifts the target address into those registers over three lines: shift clock, serial data and latch strobe. It then runs a write cycle on the parallel data bus with its own chip-enable and read/write line, followed by a read-back. The loader has no control of the processor clock phase, so a write can fail to reach the RAM. A byte is therefore written again until the read-back matches, up to a parameterised number of attempts. After the last byte is verified, the loader asserts system reset, then gives the bus back, then releases reset after a minimum hold time.

A free-running divider produces a 50 Hz (or 60 Hz) square wave for a peripheral time-of-day input. Each later image repeats the whole sequence.

Top module: `bl_boot_loader`

## Requirements
- R1: After reset the loader is idle: cpu_be=1 (processor owns the bus), sr_oe_n=1, sys_rst_n=1, ram_ce_n=1, ram_rw=1, data_oe=0, load_err=0, tod=0, and in_ready=1.
- R2: A byte accepted while idle drives cpu_be to 0 and sr_oe_n to 0 before any RAM access. cpu_be=1 forces ram_ce_n=1 and data_oe=0. in_ready is 0 while a byte is being shifted, written or checked.
- R3: Before the first RAM access of each byte, the address is sent most significant bit first. sr_data is stable at each of AW rising sr_clk edges, and one sr_latch pulse follows with sr_clk low. The k-th byte of an image (counting from 0) goes to LOAD_BASE+k.
- R4: A write attempt holds ram_ce_n=0, ram_rw=0 (0 = write, 1 = read) and data_oe=1 with the byte on data_out. The read-back that follows holds ram_ce_n=0, ram_rw=1, data_oe=0 and compares data_in with the byte.
- R5: A mismatching read-back repeats the write and read-back at the same latched address without reshifting it. A byte that verifies on attempt k costs exactly k write attempts.
- R6: If RETRY_MAX attempts on one byte all mismatch, load_err becomes 1, the bus returns to the processor with no reset pulse, and later bytes up to and including the one flagged in_last are accepted and discarded. load_err clears when the next image's first byte is accepted.
- R7: After the last byte verifies, sys_rst_n falls while cpu_be is still 0, then cpu_be rises while sys_rst_n is still 0, then sys_rst_n rises.
- R8: sys_rst_n stays low for exactly RST_HOLD clock cycles per completed load.
- R9: tod toggles every CLK_HZ/(2*TOD_HZ) clock cycles, independent of any load activity.
- R10: A new image after a completed or aborted load repeats the full sequence and starts again at LOAD_BASE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Image byte present on in_data |
| in_data | input | DW | Image byte |
| in_last | input | 1 | Marks the final byte of an image |
| in_ready | output | 1 | Loader accepts a byte this cycle |
| cpu_be | output | 1 | Processor bus enable, 0 floats the processor |
| sys_rst_n | output | 1 | Active-low system reset |
| sr_oe_n | output | 1 | Active-low output enable of the address shift registers |
| sr_clk | output | 1 | Address shift clock |
| sr_data | output | 1 | Address serial data |
| sr_latch | output | 1 | Address latch strobe |
| ram_ce_n | output | 1 | Loader RAM chip enable, active low |
| ram_rw | output | 1 | 1 read, 0 write |
| data_oe | output | 1 | Loader drives data_out onto the data bus |
| data_out | output | DW | Data driven during writes |
| data_in | input | DW | Data bus value seen during read-back |
| load_err | output | 1 | Last load aborted after RETRY_MAX failed attempts |
| tod | output | 1 | Time-of-day square wave |

## Verification
A sequencer in the wrong state shows up quickly at the ports. Within one cycle, bus-enable, reset or the RAM strobes break their ordering. The latched address that the external shift registers would hold is wrong at the next latch strobe. A bad retry count shows as an extra or missing write attempt on the data bus, and a bad abort shows in load_err and in RAM contents once the image ends. A divider fault moves the tod edge away from its expected cycle by the first half period.

// File: rtl/bl_pkg.sv
package bl_pkg;

  typedef enum logic [2:0] {
    CT_IDLE,
    CT_SHIFT,
    CT_CYCLE,
    CT_NEXT,
    CT_RST_ON,
    CT_RST_WAIT,
    CT_DRAIN
  } ctl_state_e;

  typedef enum logic [2:0] {
    BC_IDLE,
    BC_WRITE,
    BC_GAP,
    BC_READ,
    BC_DONE
  } bc_state_e;

endpackage

// File: rtl/bl_addr_ser.sv
module bl_addr_ser #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  output logic          sr_clk,
  output logic          sr_data,
  output logic          sr_latch,
  output logic          done
);
  localparam int CW = $clog2(AW + 1);

  logic          active_q, active_d;
  logic          phase_q, phase_d;
  logic          latch_q, latch_d;
  logic          done_q, done_d;
  logic [CW-1:0] bit_q, bit_d;
  logic [AW-1:0] sh_q, sh_d;

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    latch_d  = 1'b0;
    done_d   = latch_q;
    if (!active_q) begin
      if (start) begin
        sh_d     = addr;
        active_d = 1'b1;
        phase_d  = 1'b0;
        bit_d    = '0;
      end
    end else if (!phase_q) begin
      phase_d = 1'b1;
    end else begin
      phase_d = 1'b0;
      if (bit_q == CW'(AW - 1)) begin
        active_d = 1'b0;
        latch_d  = 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
        sh_d  = {sh_q[AW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      latch_q  <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      latch_q  <= latch_d;
      done_q   <= done_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
    end
  end

  assign sr_clk   = phase_q;
  assign sr_data  = sh_q[AW-1];
  assign sr_latch = latch_q;
  assign done     = done_q;

  // R3: serial data must not move on a rising shift edge
  a_r3_data_stable_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_clk) |-> $stable(sr_data));
  // R3: latch strobe never overlaps a shift clock
  a_r3_latch_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    sr_latch |-> !sr_clk);
  // R3: done follows the latch strobe
  a_r3_done_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    sr_latch |=> done);

endmodule

// File: rtl/bl_bus_cycle.sv
module bl_bus_cycle
  import bl_pkg::*;
#(
  parameter int DW     = 8,
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] rd_data,
  output logic          ram_ce_n,
  output logic          ram_rw,
  output logic          data_oe,
  output logic [DW-1:0] data_out,
  output logic          done,
  output logic          match
);
  localparam int MAXC = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int CCW  = $clog2(MAXC + 1);

  bc_state_e      st_q, st_d;
  logic [CCW-1:0] cnt_q, cnt_d;
  logic           match_q, match_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    match_d = match_q;
    case (st_q)
      BC_IDLE, BC_DONE: begin
        st_d = BC_IDLE;
        if (start) begin
          st_d  = BC_WRITE;
          cnt_d = '0;
        end
      end
      BC_WRITE: begin
        if (cnt_q == CCW'(WR_CYC - 1)) st_d = BC_GAP;
        else cnt_d = cnt_q + 1'b1;
      end
      BC_GAP: begin
        st_d  = BC_READ;
        cnt_d = '0;
      end
      BC_READ: begin
        if (cnt_q == CCW'(RD_CYC - 1)) begin
          match_d = (rd_data == wr_data);
          st_d    = BC_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = BC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BC_IDLE;
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      match_q <= match_d;
    end
  end

  assign ram_ce_n = !((st_q == BC_WRITE) || (st_q == BC_READ));
  assign ram_rw   = (st_q != BC_WRITE);
  assign data_oe  = (st_q == BC_WRITE);
  assign data_out = (st_q == BC_WRITE) ? wr_data : '0;
  assign done     = (st_q == BC_DONE);
  assign match    = match_q;

  // R4: a write strobe is always qualified by chip enable
  a_r4_write_has_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_rw |-> !ram_ce_n);
  // R4: data is driven only while writing
  a_r4_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !ram_rw);
  // R5: each attempt reports completion for a single cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/bl_tod_gen.sv
module bl_tod_gen #(
  parameter int CLK_HZ = 1_000_000,
  parameter int TOD_HZ = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tod
);
  localparam int HALF = CLK_HZ / (2 * TOD_HZ);
  localparam int TW   = $clog2(HALF + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          tod_q, tod_d;
  logic          tick;

  assign tick = (cnt_q == TW'(HALF - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    tod_d = tick ? !tod_q : tod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tod_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tod_q <= tod_d;
    end
  end

  assign tod = tod_q;

  // R9: the wave holds between divider terminal counts
  a_r9_tod_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tod));

endmodule

// File: rtl/bl_boot_loader.sv
module bl_boot_loader
  import bl_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int LOAD_BASE = 0,
  parameter int RETRY_MAX = 8,
  parameter int RST_HOLD  = 16,
  parameter int WR_CYC    = 2,
  parameter int RD_CYC    = 2,
  parameter int CLK_HZ    = 1_000_000,
  parameter int TOD_HZ    = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          cpu_be,
  output logic          sys_rst_n,
  output logic          sr_oe_n,
  output logic          sr_clk,
  output logic          sr_data,
  output logic          sr_latch,
  output logic          ram_ce_n,
  output logic          ram_rw,
  output logic          data_oe,
  output logic [DW-1:0] data_out,
  input  logic [DW-1:0] data_in,
  output logic          load_err,
  output logic          tod
);
  localparam int TRW = $clog2(RETRY_MAX + 1);
  localparam int HW  = $clog2(RST_HOLD + 1);

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  ctl_state_e     st_q, st_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [DW-1:0]  byte_q, byte_d;
  logic           last_q, last_d;
  logic [TRW-1:0] tries_q, tries_d;
  logic [HW-1:0]  hold_q, hold_d;
  logic           err_q, err_d;
  logic           ser_start, ser_done;
  logic           bc_start, bc_done, bc_match;
  logic           accept;

  assign in_ready = (st_q == CT_IDLE) || (st_q == CT_NEXT) || (st_q == CT_DRAIN);
  assign accept   = in_valid && in_ready;

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    byte_d    = byte_q;
    last_d    = last_q;
    tries_d   = tries_q;
    hold_d    = hold_q;
    err_d     = err_q;
    ser_start = 1'b0;
    bc_start  = 1'b0;
    case (st_q)
      CT_IDLE: begin
        if (accept) begin
          byte_d    = in_data;
          last_d    = in_last;
          addr_d    = AW'(LOAD_BASE);
          tries_d   = '0;
          err_d     = 1'b0;
          ser_start = 1'b1;
          st_d      = CT_SHIFT;
        end
      end
      CT_SHIFT: begin
        if (ser_done) begin
          bc_start = 1'b1;
          st_d     = CT_CYCLE;
        end
      end
      CT_CYCLE: begin
        if (bc_done) begin
          if (bc_match) begin
            if (last_q) begin
              hold_d = '0;
              st_d   = CT_RST_ON;
            end else begin
              st_d = CT_NEXT;
            end
          end else if (tries_q == TRW'(RETRY_MAX - 1)) begin
            err_d = 1'b1;
            st_d  = last_q ? CT_IDLE : CT_DRAIN;
          end else begin
            tries_d  = tries_q + 1'b1;
            bc_start = 1'b1;
          end
        end
      end
      CT_NEXT: begin
        if (accept) begin
          byte_d    = in_data;
          last_d    = in_last;
          addr_d    = addr_q + 1'b1;
          tries_d   = '0;
          ser_start = 1'b1;
          st_d      = CT_SHIFT;
        end
      end
      CT_RST_ON: begin
        hold_d = HW'(1);
        st_d   = CT_RST_WAIT;
      end
      CT_RST_WAIT: begin
        if (hold_q == HW'(RST_HOLD - 1)) st_d = CT_IDLE;
        else hold_d = hold_q + 1'b1;
      end
      CT_DRAIN: begin
        if (accept && in_last) st_d = CT_IDLE;
      end
      default: st_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= CT_IDLE;
      addr_q  <= '0;
      byte_q  <= '0;
      last_q  <= 1'b0;
      tries_q <= '0;
      hold_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      byte_q  <= byte_d;
      last_q  <= last_d;
      tries_q <= tries_d;
      hold_q  <= hold_d;
      err_q   <= err_d;
    end
  end

  assign cpu_be    = (st_q == CT_IDLE) || (st_q == CT_RST_WAIT) || (st_q == CT_DRAIN);
  assign sr_oe_n   = cpu_be;
  assign sys_rst_n = !((st_q == CT_RST_ON) || (st_q == CT_RST_WAIT));
  assign load_err  = err_q;

  bl_addr_ser #(.AW(AW)) u_ser (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (ser_start),
    .addr     (addr_d),
    .sr_clk   (sr_clk),
    .sr_data  (sr_data),
    .sr_latch (sr_latch),
    .done     (ser_done)
  );

  bl_bus_cycle #(.DW(DW), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) u_bus (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (bc_start),
    .wr_data  (byte_q),
    .rd_data  (data_in),
    .ram_ce_n (ram_ce_n),
    .ram_rw   (ram_rw),
    .data_oe  (data_oe),
    .data_out (data_out),
    .done     (bc_done),
    .match    (bc_match)
  );

  bl_tod_gen #(.CLK_HZ(CLK_HZ), .TOD_HZ(TOD_HZ)) u_tod (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tod   (tod)
  );

  // R2: no loader RAM access while the processor owns the bus
  a_r2_quiet_when_cpu_owns: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_be |-> (ram_ce_n && !data_oe));
  // R7: bus is already returned when reset releases
  a_r7_bus_back_first: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sys_rst_n) |-> $past(cpu_be));
  // R7: bus is returned only under reset, except on abort
  a_r7_reset_covers_handback: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(cpu_be) |-> (!sys_rst_n || load_err));
  // R6: an aborted load leaves the bus with the processor
  a_r6_err_bus_free: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_err |-> cpu_be);
  // R5: attempt counter stays inside its limit
  a_r5_tries_bounded: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == CT_CYCLE) |-> (tries_q < TRW'(RETRY_MAX)));

endmodule

// File: tb/bl_boot_loader_bench.sv
module bl_boot_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int LOAD_BASE = 'h1F0;
  localparam int RETRY_MAX = 4;
  localparam int RST_HOLD = 5;
  localparam int CLK_HZ = 2000;
  localparam int TOD_HZ = 50;
  localparam int HALF = CLK_HZ / (2 * TOD_HZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready, cpu_be, sys_rst_n, sr_oe_n, sr_clk, sr_data, sr_latch;
  logic ram_ce_n, ram_rw, data_oe, load_err, tod;
  logic [DW-1:0] data_out, data_in;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] mem [0:1023];
  logic [7:0] exp_mem [0:1023];
  logic [15:0] sh = '0;
  logic [15:0] lat = '0;
  int sclk_cnt = 0;
  int lat_cnt = 0;
  int wr_starts = 0;
  int lose_addr = -1;
  int lose_cnt = 0;
  int rst_pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bl_boot_loader #(
    .AW(AW), .DW(DW), .LOAD_BASE(LOAD_BASE), .RETRY_MAX(RETRY_MAX),
    .RST_HOLD(RST_HOLD), .WR_CYC(2), .RD_CYC(2), .CLK_HZ(CLK_HZ), .TOD_HZ(TOD_HZ)
  ) u_bl_boot_loader (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .cpu_be(cpu_be),
    .sys_rst_n(sys_rst_n), .sr_oe_n(sr_oe_n), .sr_clk(sr_clk),
    .sr_data(sr_data), .sr_latch(sr_latch), .ram_ce_n(ram_ce_n),
    .ram_rw(ram_rw), .data_oe(data_oe), .data_out(data_out),
    .data_in(data_in), .load_err(load_err), .tod(tod)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int img, input int i);
    return 8'((img * 16 + i * 3 + 1) & 255);
  endfunction

  // RAM read path: RAM answers only a loader read cycle
  assign data_in = (!ram_ce_n && ram_rw && !sr_oe_n) ? mem[lat[9:0]] : '0;

  // external shift register and latch model
  always @(posedge sr_clk or posedge sr_latch) begin
    if (sr_latch && !sr_clk) begin
      chk(sclk_cnt == AW, "R3", "shift clocks before latch", sclk_cnt, AW);
      chk(sh == 16'(LOAD_BASE + lat_cnt), "R3", "latched address", sh, LOAD_BASE + lat_cnt);
      chk(!cpu_be && !sr_oe_n && !in_ready, "R2", "bus held, stream stalled at latch",
          {cpu_be, sr_oe_n, in_ready}, 0);
      lat = sh;
      lat_cnt++;
      sclk_cnt = 0;
    end else begin
      sh = {sh[14:0], sr_data};
      sclk_cnt++;
    end
  end

  // RAM write model with injected lost writes
  logic wr_prev = 1'b0, rd_prev = 1'b0, drop_cur = 1'b0;
  always @(negedge clk) begin
    logic wr, rd;
    wr = rst_n && !ram_ce_n && !ram_rw;
    rd = rst_n && !ram_ce_n && ram_rw;
    if (wr && !wr_prev) begin
      wr_starts++;
      chk(data_oe == 1'b1, "R4", "data driven during write", data_oe, 1);
      drop_cur = (int'(lat) == lose_addr) && (lose_cnt > 0);
      if (drop_cur) lose_cnt--;
    end
    if (rd && !rd_prev)
      chk(data_oe == 1'b0, "R4", "data released during read-back", data_oe, 0);
    if (wr && !drop_cur && data_oe) mem[lat[9:0]] = data_out;
    wr_prev = wr;
    rd_prev = rd;
  end

  // reset / bus-enable ordering monitor
  logic prev_rst = 1'b1, prev_be = 1'b1;
  int low_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!sys_rst_n && prev_rst) begin
        chk(cpu_be == 1'b0, "R7", "bus still held when reset falls", cpu_be, 0);
        low_cnt = 1;
        rst_pulses++;
      end else if (!sys_rst_n) begin
        low_cnt++;
      end
      if (sys_rst_n && !prev_rst) begin
        chk(cpu_be == 1'b1, "R7", "bus returned before reset rises", cpu_be, 1);
        chk(low_cnt == RST_HOLD, "R8", "reset low cycles", low_cnt, RST_HOLD);
      end
      if (cpu_be && !prev_be)
        chk(!sys_rst_n || load_err, "R7", "bus returned under reset", sys_rst_n, 0);
      prev_rst = sys_rst_n;
      prev_be = cpu_be;
    end
  end

  // time-of-day period monitor
  logic tod_prev = 1'b0;
  bit tod_seen = 0;
  int tod_cnt = 0;
  int tod_checks = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      tod_cnt++;
      if (tod !== tod_prev) begin
        if (tod_seen && tod_checks < 12) begin
          chk(tod_cnt == HALF, "R9", "tod half period", tod_cnt, HALF);
          tod_checks++;
        end
        tod_seen = 1;
        tod_cnt = 0;
      end
      tod_prev = tod;
    end
  end

  task automatic run_image(input int img, input int n, input int lose_idx,
                           input int lose_n);
    bit exp_err;
    int exp_wr, exp_lat, pulses0;
    exp_err = (lose_n >= RETRY_MAX);
    lose_addr = (lose_n > 0) ? LOAD_BASE + lose_idx : -1;
    lose_cnt = lose_n;
    lat_cnt = 0;
    wr_starts = 0;
    pulses0 = rst_pulses;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = pat(img, i);
      in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (cpu_be && sys_rst_n && in_ready) break;
      @(negedge clk);
    end
    for (int i = 0; i < n; i++)
      if (!exp_err || i < lose_idx) exp_mem[(LOAD_BASE + i) & 1023] = pat(img, i);
    exp_wr  = exp_err ? lose_idx + RETRY_MAX : n + lose_n;
    exp_lat = exp_err ? lose_idx + 1 : n;
    chk(load_err == exp_err, "R6", "load_err after image", load_err, exp_err);
    chk(wr_starts == exp_wr, "R5", "write attempts", wr_starts, exp_wr);
    chk(lat_cnt == exp_lat, "R5", "address latches (no reshift on retry)", lat_cnt, exp_lat);
    chk(rst_pulses - pulses0 == (exp_err ? 0 : 1), "R7", "reset pulses per load",
        rst_pulses - pulses0, exp_err ? 0 : 1);
    chk(cpu_be && sys_rst_n && in_ready, "R10", "idle again after load",
        {cpu_be, sys_rst_n, in_ready}, 3'b111);
    for (int i = 0; i < n + 2; i++) begin
      int a;
      a = (LOAD_BASE + i) & 1023;
      chk(mem[a] == exp_mem[a], exp_err ? "R6" : "R4", "RAM content", mem[a], exp_mem[a]);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle state after reset
    chk(cpu_be == 1 && sr_oe_n == 1 && sys_rst_n == 1, "R1", "bus/reset idle",
        {cpu_be, sr_oe_n, sys_rst_n}, 3'b111);
    chk(ram_ce_n == 1 && ram_rw == 1 && data_oe == 0, "R1", "RAM strobes idle",
        {ram_ce_n, ram_rw, data_oe}, 3'b110);
    chk(load_err == 0 && tod == 0 && in_ready == 1, "R1", "flags idle",
        {load_err, tod, in_ready}, 3'b001);

    run_image(1, 8, 0, 0);                // clean load
    run_image(2, 20, 5, RETRY_MAX - 1);   // success on the last allowed attempt, crosses 0x1FF
    run_image(3, 6, 2, RETRY_MAX);        // abort with drain (R6)
    run_image(4, 1, 0, RETRY_MAX);        // abort on the final byte
    run_image(5, 3, 1, 1);                // error cleared, restart at base (R10)
    for (int len = 1; len <= 6; len++)
      for (int k = 0; k < 3; k++)
        run_image(6 + len * 3 + k, len, len - 1, k);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule